// File: doc/BRIEF.md
# Operate Group Two Non-Skip Unit

This block carries out the non-skip half of the second operate microinstruction group of a 12-bit accumulator machine. It holds the accumulator, the program counter, a memory-address register that tracks the program counter, and a run/halt state. The instruction register value and the front-panel switch register come in as plain inputs. While halted, the accumulator and program counter may be loaded from the panel. A continue pulse starts execution. Each executed instruction takes a fixed number of phase cycles and advances the program counter by one. While the machine runs, the same instruction word is executed again and again.

Three select bits act inside the group. The clear bit empties the accumulator. The switch bit then ORs the switch register into the result. The halt bit drops the machine back to the halted state once that instruction has fully completed. A stop input has the same effect at the end of the current instruction. The skip-condition bits are accepted but never cause a skip. Instruction words outside the group leave the accumulator alone and only advance the program counter.

Top module: `opr2_nonskip_unit`

## Requirements
- R1: A word belongs to the group when bits 11..8 are all ones and bit 0 is zero (octal 74xx, even). Any other word, for example octal 7603 or 7200, leaves the accumulator unchanged and advances the program counter by one.
- R2: With the halt bit (octal 0002, bit 1) set in a group word, the instruction completes with the program counter advanced by one, and running_o then falls. Octal 7402 leaves the accumulator unchanged.
- R3: Each continue pulse given while halted executes the instruction once more and advances the program counter by one more.
- R4: The clear bit (octal 0200, bit 7) sets the accumulator to 0000. Octal 7612 gives an accumulator of 0000, an advanced program counter and a halt.
- R5: The switch bit (octal 0004, bit 2) ORs sw_i into the accumulator after any clear. Octal 7614 leaves the accumulator equal to the switches. Under octal 7404 a bit that has been set stays set after its switch returns to 0.
- R6: Without a halt bit the machine keeps running. done_o pulses once per completed instruction, and the program counter advances by exactly the number of pulses.
- R7: A stop pulse given while running halts the machine at the end of the current instruction, no more than PHASES cycles later. That instruction's updates are still applied.
- R8: The program counter wraps from 7777 to 0000.
- R9: ma_o always equals pc_o, both after a panel load and after execution.
- R10: Panel loads of the accumulator and program counter take effect only while halted. While running they are ignored.
- R11: The skip bits (octal 0100, 0040, 0020, 0010) have no effect. Octal 7572 advances the program counter by exactly one and leaves the accumulator unchanged.
- R12: An instruction takes PHASES cycles. For a halting instruction, running_o stays high for exactly PHASES cycles after the continue pulse is sampled.
- R13: After reset the machine is halted, the accumulator and program counter are 0000, and done_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 12 | Instruction register value |
| sw_i | input | 12 | Front-panel switch register |
| ac_ld_i | input | 1 | Panel load strobe for the accumulator |
| ac_val_i | input | 12 | Panel value for the accumulator |
| pc_ld_i | input | 1 | Panel load strobe for the program counter |
| pc_val_i | input | 12 | Panel value for the program counter |
| cont_i | input | 1 | Continue pulse, starts running from halt |
| stop_i | input | 1 | Stop request, honoured at instruction end |
| ac_o | output | 12 | Accumulator |
| pc_o | output | 12 | Program counter |
| ma_o | output | 12 | Memory-address register, tracks the program counter |
| running_o | output | 1 | High while the machine runs |
| done_o | output | 1 | One-cycle pulse after each completed instruction |

## Verification
The bench runs several instruction words through the same run/halt sequence, and each result separates one behaviour from the others:
- Halt only (7402) shows that the accumulator is left alone while the program counter still advances.
- Clear with halt (7612) shows that clearing works.
- Clear with switches (7614) shows that the clear comes before the OR, since the result equals the switches exactly.
- Switches alone (7404) with a switch that is later released shows that the OR keeps bits that were already set.
- The skip-bit word (7572) shows that no skip is taken.
- The two words outside the group (7603, 7200) show the decode boundary: each carries the clear bit, yet the accumulator keeps its value.

Continuous runs with a stop pulse relate the done count to the program counter step and bound the stop latency. Panel loads issued during a run show that the loads are blocked while running.

// File: rtl/opr2_pkg.sv
package opr2_pkg;
   localparam int unsigned WORD_W  = 12;
   localparam int unsigned B_CLA   = 7;
   localparam int unsigned B_OSR   = 2;
   localparam int unsigned B_HLT   = 1;
   localparam int unsigned B_SKLO  = 3;
   localparam int unsigned B_SKHI  = 6;
   localparam int unsigned B_GRPLO = 8;

   typedef struct packed {
      logic grp2;
      logic cla;
      logic osr;
      logic hlt;
      logic skp;
   } op_sel_t;
endpackage

// File: rtl/opr2_decode.sv
module opr2_decode
   import opr2_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  logic [W-1:0] instr_i,
   output op_sel_t      sel_o
);
   localparam int unsigned GRP_BITS = W - B_GRPLO;

   if (W != WORD_W) begin : g_bad_w
      $error("opr2_decode: word width must be 12");
   end

   logic in_grp;
   // R1: bits 11..8 all ones and bit 0 clear
   assign in_grp = (&instr_i[W-1:B_GRPLO]) && !instr_i[0];

   always_comb begin
      sel_o      = '0;
      sel_o.grp2 = in_grp;
      sel_o.cla  = in_grp && instr_i[B_CLA];
      sel_o.osr  = in_grp && instr_i[B_OSR];
      sel_o.hlt  = in_grp && instr_i[B_HLT];
      // R11: skip field decoded but never acted on
      sel_o.skp  = in_grp && (|instr_i[B_SKHI:B_SKLO]);
   end

   initial begin
      assert (GRP_BITS == 4) else $error("opr2_decode: group field width");
   end
endmodule

// File: rtl/opr2_runctl.sv
module opr2_runctl #(
   parameter int unsigned PHASES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cont_i,
   input  logic stop_i,
   input  logic halt_req_i,
   output logic run_o,
   output logic complete_o,
   output logic done_o
);
   localparam int unsigned PH_W = (PHASES > 1) ? $clog2(PHASES) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

   if (PHASES < 1) begin : g_bad_ph
      $error("opr2_runctl: PHASES must be at least 1");
   end

   logic run_q;
   logic pend_q;
   logic done_q;
   logic complete;

   if (PHASES == 1) begin : g_single
      assign complete = run_q;
   end else begin : g_multi
      logic [PH_W-1:0] ph_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ph_q <= '0;
         end else if (!run_q || complete) begin
            ph_q <= '0;
         end else begin
            ph_q <= ph_q + 1'b1;
         end
      end
      assign complete = run_q && (ph_q == PH_LAST);

      a_r12_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
         ph_q <= PH_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= complete;
         if (!run_q) begin
            pend_q <= 1'b0;
            if (cont_i) run_q <= 1'b1;
         end else if (complete) begin
            pend_q <= 1'b0;
            if (halt_req_i || stop_i || pend_q) run_q <= 1'b0;
         end else if (stop_i) begin
            pend_q <= 1'b1;
         end
      end
   end

   assign run_o      = run_q;
   assign complete_o = complete;
   assign done_o     = done_q;

   a_r2_halt_drops_run: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && halt_req_i) |=> !run_q);
   a_r7_stop_honoured: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && (stop_i || pend_q)) |=> !run_q);
   a_r3_cont_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && cont_i) |=> run_q);
   a_r6_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !complete) |=> run_q);
endmodule

// File: rtl/opr2_acc.sv
module opr2_acc
   import opr2_pkg::*;
#(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         complete_i,
   input  op_sel_t      sel_i,
   input  logic [W-1:0] sw_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] ac_o
);
   logic [W-1:0] ac_q;
   logic [W-1:0] cleared;
   logic [W-1:0] merged;

   // R4 then R5: clear first, OR switches second
   assign cleared = sel_i.cla ? '0 : ac_q;
   assign merged  = cleared | (sel_i.osr ? sw_i : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q <= '0;
      end else if (complete_i) begin
         if (sel_i.grp2) ac_q <= merged;
      end else if (ld_i && !run_i) begin
         ac_q <= ld_val_i;
      end
   end

   assign ac_o = ac_q;

   a_r10_ac_held_mid_instr: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !complete_i) |=> $stable(ac_q));
   a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (complete_i && sel_i.cla && !sel_i.osr) |=> (ac_q == '0));
   a_r1_outside_group_keeps_ac: assert property (@(posedge clk) disable iff (!rst_n)
      (complete_i && !sel_i.grp2) |=> $stable(ac_q));
endmodule

// File: rtl/opr2_pc.sv
module opr2_pc #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         complete_i,
   input  logic         ld_i,
   input  logic [W-1:0] ld_val_i,
   output logic [W-1:0] pc_o,
   output logic [W-1:0] ma_o
);
   logic [W-1:0] pc_q;
   logic [W-1:0] ma_q;
   logic [W-1:0] pc_inc;

   assign pc_inc = pc_q + 1'b1;   // R8: natural wrap

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= '0;
         ma_q <= '0;
      end else if (complete_i) begin
         pc_q <= pc_inc;
         ma_q <= pc_inc;
      end else if (ld_i && !run_i) begin
         pc_q <= ld_val_i;
         ma_q <= ld_val_i;
      end
   end

   assign pc_o = pc_q;
   assign ma_o = ma_q;

   a_r6_pc_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
      complete_i |=> (pc_q == $past(pc_q) + 1'b1));
   a_r9_ma_tracks_pc: assert property (@(posedge clk) disable iff (!rst_n)
      ma_q == pc_q);
   a_r10_pc_held_mid_instr: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !complete_i) |=> $stable(pc_q));
endmodule

// File: rtl/opr2_nonskip_unit.sv
module opr2_nonskip_unit
   import opr2_pkg::*;
#(
   parameter int unsigned W      = 12,
   parameter int unsigned PHASES = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] instr_i,
   input  logic [W-1:0] sw_i,
   input  logic         ac_ld_i,
   input  logic [W-1:0] ac_val_i,
   input  logic         pc_ld_i,
   input  logic [W-1:0] pc_val_i,
   input  logic         cont_i,
   input  logic         stop_i,
   output logic [W-1:0] ac_o,
   output logic [W-1:0] pc_o,
   output logic [W-1:0] ma_o,
   output logic         running_o,
   output logic         done_o
);
   if (W != WORD_W) begin : g_bad_w
      $error("opr2_nonskip_unit: W must be 12");
   end

   op_sel_t sel;
   logic    run;
   logic    complete;

   opr2_decode #(.W(W)) u_dec (
      .instr_i (instr_i),
      .sel_o   (sel)
   );

   opr2_runctl #(.PHASES(PHASES)) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .cont_i     (cont_i),
      .stop_i     (stop_i),
      .halt_req_i (sel.hlt),
      .run_o      (run),
      .complete_o (complete),
      .done_o     (done_o)
   );

   opr2_acc #(.W(W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .complete_i (complete),
      .sel_i      (sel),
      .sw_i       (sw_i),
      .ld_i       (ac_ld_i),
      .ld_val_i   (ac_val_i),
      .ac_o       (ac_o)
   );

   opr2_pc #(.W(W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run),
      .complete_i (complete),
      .ld_i       (pc_ld_i),
      .ld_val_i   (pc_val_i),
      .pc_o       (pc_o),
      .ma_o       (ma_o)
   );

   assign running_o = run;

   a_r11_skip_no_extra_step: assert property (@(posedge clk) disable iff (!rst_n)
      (complete && sel.skp) |=> (pc_o == $past(pc_o) + 1'b1));
   a_r13_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(run));
endmodule

// File: tb/opr2_nonskip_unit_tb_top.sv
module opr2_nonskip_unit_tb_top;
   localparam int PH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] instr = '0, sw = '0, ac_val = '0, pc_val = '0;
   logic        ac_ld = 1'b0, pc_ld = 1'b0, cont = 1'b0, stop = 1'b0;
   logic [11:0] ac, pc, ma;
   logic        running, done;

   int n_chk = 0, n_fail = 0, done_cnt = 0;

   always #10 clk = ~clk;   // 50 MHz

   opr2_nonskip_unit #(.W(12), .PHASES(PH)) dut_i (
      .clk(clk), .rst_n(rst_n), .instr_i(instr), .sw_i(sw),
      .ac_ld_i(ac_ld), .ac_val_i(ac_val), .pc_ld_i(pc_ld), .pc_val_i(pc_val),
      .cont_i(cont), .stop_i(stop), .ac_o(ac), .pc_o(pc), .ma_o(ma),
      .running_o(running), .done_o(done)
   );

   always @(negedge clk) if (done) done_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0o expected %0o", req, act, exp);
      end
   endtask

   task automatic load_ac(input logic [11:0] v);
      ac_ld = 1'b1; ac_val = v; @(negedge clk); ac_ld = 1'b0;
   endtask

   task automatic load_pc(input logic [11:0] v);
      pc_ld = 1'b1; pc_val = v; @(negedge clk); pc_ld = 1'b0;
   endtask

   task automatic press_cont();
      cont = 1'b1; @(negedge clk); cont = 1'b0;
   endtask

   task automatic press_stop();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
   endtask

   task automatic wait_halt(output int cyc);
      cyc = 0;
      while (running && cyc < 1000) begin
         cyc++;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!running, "R13 running", running, 0);
      chk(ac == 0, "R13 ac", ac, 0);
      chk(pc == 0, "R13 pc", pc, 0);
      chk(!done, "R13 done", done, 0);
   endtask

   task automatic t_halt_repeat();
      int c;
      instr = 12'o7402;
      load_ac(12'o1234); load_pc(12'o0000);
      chk(ma == 0, "R9 ma after load", ma, 0);
      press_cont(); wait_halt(c);
      chk(c == PH, "R12 instr cycles", c, PH);
      chk(pc == 12'o0001, "R2 pc", pc, 1);
      chk(ac == 12'o1234, "R2 ac kept", ac, 12'o1234);
      chk(!running, "R2 halted", running, 0);
      for (int i = 2; i <= 4; i++) begin
         press_cont(); wait_halt(c);
         chk(pc == i, "R3 pc per cont", pc, i);
         chk(ac == 12'o1234, "R3 ac kept", ac, 12'o1234);
      end
   endtask

   task automatic t_clear_halt();
      int c;
      logic [11:0] p0;
      p0 = pc;
      instr = 12'o7612;
      press_cont(); wait_halt(c);
      chk(ac == 0, "R4 ac cleared", ac, 0);
      chk(pc == p0 + 12'd1, "R4 pc", pc, p0 + 1);
      chk(!running, "R4 halted", running, 0);
   endtask

   task automatic t_run_osr();
      int c;
      logic [11:0] p0;
      load_ac(12'o1234); p0 = pc;
      sw = 12'o5252; instr = 12'o7614;
      done_cnt = 0;
      press_cont();
      repeat (40) @(negedge clk);
      chk(running, "R6 still running", running, 1);
      press_stop(); wait_halt(c);
      chk(c <= PH, "R7 stop latency", c, PH);
      chk(ac == 12'o5252, "R5 ac equals switches", ac, 12'o5252);
      chk(done_cnt >= 10, "R6 done count", done_cnt, 10);
      chk(pc == 12'(p0 + done_cnt), "R6 pc step per done", pc, 12'(p0 + done_cnt));
      chk(ma == pc, "R9 ma after run", ma, pc);
   endtask

   task automatic t_osr_sticky();
      int c;
      sw = 12'o0000; load_ac(12'o0000);
      instr = 12'o7404;
      press_cont();
      sw = 12'o0010; repeat (12) @(negedge clk);
      sw = 12'o0000; repeat (12) @(negedge clk);
      sw = 12'o0001; repeat (12) @(negedge clk);
      press_stop(); wait_halt(c);
      chk(ac == 12'o0011, "R5 sticky OR", ac, 12'o0011);
   endtask

   task automatic t_load_blocked();
      int c;
      logic [11:0] p0;
      sw = 12'o0000; load_ac(12'o0000); p0 = pc;
      instr = 12'o7404; done_cnt = 0;
      press_cont();
      repeat (3) @(negedge clk);
      ac_ld = 1'b1; ac_val = 12'o7777; pc_ld = 1'b1; pc_val = 12'o4000;
      repeat (9) @(negedge clk);
      ac_ld = 1'b0; pc_ld = 1'b0;
      press_stop(); wait_halt(c);
      chk(ac == 0, "R10 ac load ignored", ac, 0);
      chk(pc == 12'(p0 + done_cnt), "R10 pc load ignored", pc, 12'(p0 + done_cnt));
   endtask

   task automatic t_wrap();
      int c;
      instr = 12'o7402; load_pc(12'o7777);
      chk(ma == 12'o7777, "R9 ma load", ma, 12'o7777);
      press_cont(); wait_halt(c);
      chk(pc == 0, "R8 wrap", pc, 0);
      chk(ma == 0, "R9 ma wrap", ma, 0);
   endtask

   task automatic t_skip_bits();
      int c;
      load_ac(12'o3141); load_pc(12'o0200);
      instr = 12'o7572;
      press_cont(); wait_halt(c);
      chk(pc == 12'o0201, "R11 pc one step", pc, 12'o0201);
      chk(ac == 12'o3141, "R11 ac kept", ac, 12'o3141);
   endtask

   task automatic t_outside(input logic [11:0] w);
      int c;
      load_ac(12'o1234); load_pc(12'o0100);
      instr = w;
      cont = 1'b1; @(negedge clk); cont = 1'b0;
      press_stop(); wait_halt(c);
      chk(ac == 12'o1234, "R1 ac untouched", ac, 12'o1234);
      chk(pc == 12'o0101, "R7 one instr after stop", pc, 12'o0101);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_halt_repeat();
      t_clear_halt();
      t_run_osr();
      t_osr_sticky();
      t_load_blocked();
      t_wrap();
      t_skip_bits();
      t_outside(12'o7603);
      t_outside(12'o7200);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule